// File: doc/BRIEF.md
# CAN Receive Frame Queue

This block buffers completed CAN frames between a controller's receive path and a host processor. Once capture is switched on, every frame the controller hands over with a one-cycle push strobe is packed into a fixed record and appended to an on-chip queue. The host no longer has to react to each frame as it arrives, because the queue holds up to 1024 of them.

Each record carries four arbitration bytes, eight data bytes and the frame's length code. The arbitration bytes are built from the identifier so that the top identifier bits come first. The host reads the number of held records at any time. It can remove the oldest record, which returns that record together with the number still left. It can also discard everything at once. A push that finds the queue full is lost, and a sticky flag records the loss until the host acknowledges it.

Top module: `can_rxq`

## Requirements
- R1: After reset, `held_count` is 0, `pop_valid` is 0 and `ovf_flag` is 0.
- R2: A push is stored only while `cap_en` is 1. A push with `cap_en` at 0 leaves `held_count` unchanged.
- R3: Arbitration word `pop_arb` (byte 0 = bits 31:24). For an extended frame (`rx_ext`=1) it is {id[28:0], 1, 00}, so byte 0 holds id[28:21] and byte 1 holds id[20:13]. For a standard frame it is {id[28:18], 21 zero bits}.
- R4: Data byte k is carried in bits [63-8k -: 8] of `pop_data`. Bytes with index at or above min(dlc, 8) read back as zero. `pop_dlc` returns the pushed length code unchanged, 0 to 15.
- R5: `held_count` equals the number of records held. It changes one cycle after the push or pop that alters it.
- R6: A pop removes the oldest record (first in, first out). One cycle later `pop_valid` is 1 for one cycle with that record, and `pop_left` gives the count after the removal.
- R7: A pop on an empty queue returns an all-zero record with `pop_left` 0, and the queue stays empty.
- R8: A stored push and a successful pop in the same cycle leave `held_count` unchanged.
- R9: The capacity is 1024 records. A push while full, with no pop in the same cycle, is dropped, sets `ovf_flag`, and leaves the held records intact.
- R10: `ovf_flag` stays set until a cycle with `host_ovf_ack` at 1 clears it. A new drop in that same cycle keeps it set.
- R11: `host_flush` empties the queue, and `held_count` is 0 in the next cycle. A push in the flush cycle is discarded without setting `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture enable |
| rx_push | input | 1 | One-cycle strobe for a completed frame |
| rx_id | input | 29 | Identifier; a standard frame uses bits 28:18 |
| rx_ext | input | 1 | 1 = extended identifier frame |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| host_pop | input | 1 | Remove the oldest record |
| host_flush | input | 1 | Discard all records |
| host_ovf_ack | input | 1 | Clear the overflow flag |
| held_count | output | 11 | Number of records held |
| pop_valid | output | 1 | Pop result valid |
| pop_arb | output | 32 | Arbitration bytes of the popped record |
| pop_data | output | 64 | Data bytes of the popped record |
| pop_dlc | output | 4 | Length code of the popped record |
| pop_left | output | 11 | Records remaining after the pop |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A table of frames runs through the queue.

- Standard and extended identifiers show whether the arbitration packing and the flag bit land in the right byte positions.
- Length codes of 0, partial lengths, 8 and values above 8 separate correct data masking from masking that is off by one or clamped wrongly.
- Distinct identifiers in a known order reveal any departure from first-in, first-out order.

Directed runs then fill the queue to exactly 1024 entries and push one more frame. They also make simultaneous push and pop requests, pop an empty queue, push with capture disabled, and flush while a push is present. These runs tell the boundary handling apart from the normal path.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
    localparam int ID_W       = 29;
    localparam int STD_ID_W   = 11;
    localparam int ARB_BYTES  = 4;
    localparam int DATA_BYTES = 8;
    localparam int DLC_W      = 4;
    localparam int ARB_W      = ARB_BYTES * 8;
    localparam int DATA_W     = DATA_BYTES * 8;

    typedef struct packed {
        logic [ARB_W-1:0]  arb;
        logic [DATA_W-1:0] data;
        logic [DLC_W-1:0]  dlc;
    } rxq_rec_t;

    localparam int REC_W = $bits(rxq_rec_t);
endpackage

// File: rtl/can_rxq_pack.sv
module can_rxq_pack
    import can_rxq_pkg::*;
(
    input  logic [ID_W-1:0]   id,
    input  logic              ext,
    input  logic [DLC_W-1:0]  dlc,
    input  logic [DATA_W-1:0] data,
    output rxq_rec_t          rec
);
    localparam int PAD_W = ARB_W - ID_W - 1;
    localparam int STD_PAD_W = ARB_W - STD_ID_W;

    logic [DLC_W:0] n_valid;

    always_comb begin
        n_valid = (dlc > DLC_W'(DATA_BYTES)) ? (DLC_W+1)'(DATA_BYTES) : {1'b0, dlc};
    end

    // Arbitration: identifier top bits first, extended flag just below the identifier
    always_comb begin
        if (ext) begin
            rec.arb = {id, 1'b1, {PAD_W{1'b0}}};
        end else begin
            rec.arb = {id[ID_W-1 -: STD_ID_W], {STD_PAD_W{1'b0}}};
        end
        rec.dlc = dlc;
    end

    for (genvar k = 0; k < DATA_BYTES; k++) begin : g_byte
        always_comb begin
            rec.data[DATA_W-1-8*k -: 8] = ((DLC_W+1)'(k) < n_valid) ? data[DATA_W-1-8*k -: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/can_rxq_store.sv
module can_rxq_store
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  rxq_rec_t      wr_rec,
    input  logic [AW-1:0] rd_addr,
    output rxq_rec_t      rd_rec
);
    logic [REC_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_rec;
        end
    end

    always_comb begin
        rd_rec = mem_q[rd_addr];
    end
endmodule

// File: rtl/can_rxq.sv
module can_rxq
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              rx_push,
    input  logic [ID_W-1:0]   rx_id,
    input  logic              rx_ext,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              host_pop,
    input  logic              host_flush,
    input  logic              host_ovf_ack,
    output logic [CW-1:0]     held_count,
    output logic              pop_valid,
    output logic [ARB_W-1:0]  pop_arb,
    output logic [DATA_W-1:0] pop_data,
    output logic [DLC_W-1:0]  pop_dlc,
    output logic [CW-1:0]     pop_left,
    output logic              ovf_flag
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          pv;
        rxq_rec_t      prec;
        logic [CW-1:0] pleft;
    } state_t;

    state_t   s_d, s_q;
    rxq_rec_t in_rec, head_rec;
    logic     full, want_push, do_push, do_pop, drop;

    can_rxq_pack i_pack (
        .id   (rx_id),
        .ext  (rx_ext),
        .dlc  (rx_dlc),
        .data (rx_data),
        .rec  (in_rec)
    );

    can_rxq_store #(.DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .wr_en   (do_push),
        .wr_addr (s_q.wr),
        .wr_rec  (in_rec),
        .rd_addr (s_q.rd),
        .rd_rec  (head_rec)
    );

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        s_d       = s_q;
        full      = (s_q.cnt == CW'(DEPTH));
        want_push = cap_en && rx_push && !host_flush;
        do_pop    = host_pop && (s_q.cnt != '0) && !host_flush;
        do_push   = want_push && (!full || do_pop);
        drop      = want_push && full && !do_pop;

        s_d.pv   = host_pop;
        s_d.prec = '0;
        if (host_flush) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.wr = step(s_q.wr);
            end
            if (do_pop) begin
                s_d.rd   = step(s_q.rd);
                s_d.prec = head_rec;
            end
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
        s_d.pleft = host_pop ? s_d.cnt : '0;

        if (drop) begin
            s_d.ovf = 1'b1;
        end else if (host_ovf_ack) begin
            s_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign held_count = s_q.cnt;
    assign pop_valid  = s_q.pv;
    assign pop_arb    = s_q.prec.arb;
    assign pop_data   = s_q.prec.data;
    assign pop_dlc    = s_q.prec.dlc;
    assign pop_left   = s_q.pleft;
    assign ovf_flag   = s_q.ovf;
endmodule

// File: rtl/can_rxq_chk.sv
module can_rxq_chk
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic              rx_push,
    input logic [ID_W-1:0]   rx_id,
    input logic              rx_ext,
    input logic [DLC_W-1:0]  rx_dlc,
    input logic [DATA_W-1:0] rx_data,
    input logic              host_pop,
    input logic              host_flush,
    input logic              host_ovf_ack,
    input logic [CW-1:0]     held_count,
    input logic              pop_valid,
    input logic [ARB_W-1:0]  pop_arb,
    input logic [DATA_W-1:0] pop_data,
    input logic [DLC_W-1:0]  pop_dlc,
    input logic [CW-1:0]     pop_left,
    input logic              ovf_flag
);
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        held_count <= CW'(DEPTH));

    p_push_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && rx_push && !host_pop && !host_flush && held_count < CW'(DEPTH)
        |=> held_count == $past(held_count) + CW'(1));

    p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en && !host_pop && !host_flush |=> $stable(held_count));

    p_pop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_pop |=> pop_valid);

    p_no_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_pop |=> !pop_valid);

    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_pop && held_count == '0 && !(cap_en && rx_push)
        |=> pop_valid && pop_left == '0 && pop_arb == '0 && pop_data == '0 && pop_dlc == '0);

    p_push_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && rx_push && host_pop && !host_flush && held_count != '0
        |=> $stable(held_count));

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && rx_push && !host_pop && !host_flush && held_count == CW'(DEPTH)
        |=> ovf_flag && held_count == CW'(DEPTH));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !host_ovf_ack |=> ovf_flag);

    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_flush |=> held_count == '0);
endmodule

bind can_rxq can_rxq_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_can_rxq.sv
module test_can_rxq;
    import can_rxq_pkg::*;

    localparam int DEPTH = 1024;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int VEC_W = ID_W + 1 + DLC_W + DATA_W;
    localparam int NVEC  = 8;

    // vector: {id, ext, dlc, data}
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {29'h0A5C0000, 1'b0, 4'd0,  64'h1122334455667788},
        {29'h1FFFFFFF, 1'b1, 4'd8,  64'h0123456789ABCDEF},
        {29'h15555555, 1'b1, 4'd3,  64'hAABBCCDDEEFF0011},
        {29'h1FFC0000, 1'b0, 4'd8,  64'hF0E1D2C3B4A59687},
        {29'h0000ABCD, 1'b0, 4'd5,  64'h5566778899AABBCC},
        {29'h0ABCDEF1, 1'b1, 4'd12, 64'hDEADBEEFCAFEF00D},
        {29'h00000001, 1'b1, 4'd1,  64'h7F00000000000001},
        {29'h12345678, 1'b0, 4'd7,  64'h0102030405060708}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cap_en = 1'b0;
    logic              rx_push = 1'b0;
    logic [ID_W-1:0]   rx_id = '0;
    logic              rx_ext = 1'b0;
    logic [DLC_W-1:0]  rx_dlc = '0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              host_pop = 1'b0;
    logic              host_flush = 1'b0;
    logic              host_ovf_ack = 1'b0;
    logic [CW-1:0]     held_count;
    logic              pop_valid;
    logic [ARB_W-1:0]  pop_arb;
    logic [DATA_W-1:0] pop_data;
    logic [DLC_W-1:0]  pop_dlc;
    logic [CW-1:0]     pop_left;
    logic              ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_rxq #(.DEPTH(DEPTH)) i_can_rxq (.*);

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ARB_W-1:0] exp_arb(input logic [ID_W-1:0] id, input logic ext);
        logic [ARB_W-1:0] a;
        a = '0;
        if (ext) begin
            a[31:24] = id[28:21];
            a[23:16] = id[20:13];
            a[15:8]  = id[12:5];
            a[7:3]   = id[4:0];
            a[2]     = 1'b1;
        end else begin
            a[31:21] = id[28:18];
        end
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] exp_data(input logic [DATA_W-1:0] d, input logic [DLC_W-1:0] dlc);
        logic [DATA_W-1:0] r;
        int n;
        n = (dlc > 8) ? 8 : int'(dlc);
        r = '0;
        for (int k = 0; k < n; k++) r[63-8*k -: 8] = d[63-8*k -: 8];
        return r;
    endfunction

    task automatic push(input logic [ID_W-1:0] id, input logic ext, input logic [DLC_W-1:0] dlc,
                        input logic [DATA_W-1:0] d);
        rx_push = 1'b1; rx_id = id; rx_ext = ext; rx_dlc = dlc; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop();
        host_pop = 1'b1;
        @(negedge clk);
        host_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(held_count == 0, "R1 count", 128'(held_count), 0);
        chk(pop_valid == 0, "R1 pop_valid", 128'(pop_valid), 0);
        chk(ovf_flag == 0, "R1 ovf", 128'(ovf_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 capture disabled: push ignored
        push(29'h1, 1'b1, 4'd8, 64'hFFFF);
        chk(held_count == 0, "R2 disabled push", 128'(held_count), 0);
        // R7 pop on empty
        pop();
        chk(pop_valid == 1, "R7 valid", 128'(pop_valid), 1);
        chk(pop_arb == 0 && pop_data == 0 && pop_dlc == 0, "R7 zero record",
            {pop_arb, pop_data}, 0);
        chk(pop_left == 0 && held_count == 0, "R7 left", 128'(pop_left), 0);

        // table walk: R3 R4 R5 R6
        cap_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][97:69], VEC[i][68], VEC[i][67:64], VEC[i][63:0]);
            chk(held_count == CW'(i + 1), "R5 count after push", 128'(held_count), 128'(i + 1));
        end
        for (int i = 0; i < NVEC; i++) begin
            pop();
            chk(pop_valid == 1, "R6 valid", 128'(pop_valid), 1);
            chk(pop_arb == exp_arb(VEC[i][97:69], VEC[i][68]), "R3 arbitration",
                128'(pop_arb), 128'(exp_arb(VEC[i][97:69], VEC[i][68])));
            chk(pop_data == exp_data(VEC[i][63:0], VEC[i][67:64]), "R4 data",
                128'(pop_data), 128'(exp_data(VEC[i][63:0], VEC[i][67:64])));
            chk(pop_dlc == VEC[i][67:64], "R4 dlc", 128'(pop_dlc), 128'(VEC[i][67:64]));
            chk(pop_left == CW'(NVEC - 1 - i), "R6 left", 128'(pop_left), 128'(NVEC - 1 - i));
        end
        @(negedge clk);
        chk(pop_valid == 0, "R6 single-cycle valid", 128'(pop_valid), 0);

        // R8 push and pop together
        push(29'h100, 1'b1, 4'd2, 64'h1);
        push(29'h200, 1'b1, 4'd2, 64'h2);
        rx_push = 1'b1; rx_id = 29'h300; rx_ext = 1'b1; rx_dlc = 4'd2; rx_data = 64'h3;
        host_pop = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; host_pop = 1'b0;
        chk(held_count == 2, "R8 count stable", 128'(held_count), 2);
        chk(pop_arb == exp_arb(29'h100, 1'b1), "R8 oldest out", 128'(pop_arb), 128'(exp_arb(29'h100, 1'b1)));
        chk(pop_left == 2, "R8 left", 128'(pop_left), 2);
        host_flush = 1'b1;
        @(negedge clk);
        host_flush = 1'b0;
        chk(held_count == 0, "R11 flush", 128'(held_count), 0);

        // R9 fill to capacity
        for (int i = 0; i < DEPTH; i++) push(ID_W'(i), 1'b1, 4'd1, 64'(i) << 56);
        chk(held_count == CW'(DEPTH), "R9 full count", 128'(held_count), 128'(DEPTH));
        chk(ovf_flag == 0, "R9 no ovf yet", 128'(ovf_flag), 0);
        push(29'h1ABCDEF0, 1'b1, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(ovf_flag == 1, "R9 ovf set", 128'(ovf_flag), 1);
        chk(held_count == CW'(DEPTH), "R9 count held", 128'(held_count), 128'(DEPTH));
        // R10 sticky then cleared, set wins over ack
        @(negedge clk);
        chk(ovf_flag == 1, "R10 sticky", 128'(ovf_flag), 1);
        rx_push = 1'b1; rx_id = 29'h5; rx_ext = 1'b1; rx_dlc = 4'd0; rx_data = '0;
        host_ovf_ack = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        chk(ovf_flag == 1, "R10 drop beats ack", 128'(ovf_flag), 1);
        @(negedge clk);
        host_ovf_ack = 1'b0;
        chk(ovf_flag == 0, "R10 cleared", 128'(ovf_flag), 0);
        pop();
        chk(pop_arb == exp_arb(29'h0, 1'b1) && pop_data == 64'h0, "R9 oldest intact",
            128'(pop_arb), 128'(exp_arb(29'h0, 1'b1)));
        chk(pop_left == CW'(DEPTH - 1), "R9 left after pop", 128'(pop_left), 128'(DEPTH - 1));
        pop();
        chk(pop_data == 64'h01 << 56, "R6 second entry", 128'(pop_data), 128'(64'h01 << 56));

        // R11 flush beats push
        rx_push = 1'b1; rx_id = 29'h7; rx_ext = 1'b0; rx_dlc = 4'd1; rx_data = '1;
        host_flush = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; host_flush = 1'b0;
        chk(held_count == 0, "R11 flush with push", 128'(held_count), 0);
        chk(ovf_flag == 0, "R11 no ovf", 128'(ovf_flag), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule